// File: doc/BRIEF.md
# Chainable Serial-to-Parallel Output Expander

This block turns a serial bit stream into parallel outputs. Bits enter a shift chain on each rising edge of a shift strobe. A separate storage strobe copies the whole chain into a holding register, and the holding register drives the parallel outputs. Because shifting and storing are independent, a controller can clock a new word into the chain while the outputs keep showing the previous word. The controller then commits the whole word in one storage edge, so the outputs never show partial data.

The chain has `NDEV` devices of `WIDTH` stages each. The serial output of device k feeds the serial input of device k+1, and the last stage of the last device is brought out as a cascade output. The strobes, the active-low clear and the active-low output enable come from outside the chip. The strobes and the clear are synchronized by two flops into one system clock domain. Each strobe then goes through a two-state edge machine. The machine is in state EDGE_LOW while the synchronized level is low. Its *rise* transition (EDGE_LOW to EDGE_HIGH) emits a one-cycle action pulse. Its *fall* transition (EDGE_HIGH to EDGE_LOW) emits nothing. While the level does not change, the machine stays in its current state.

High impedance is represented by a value vector and a matching drive-enable vector, so that a pad wrapper can build real three-state pins from them.

Top module: `expander_chain`

## Requirements
- R1: Each shift action moves every global stage j up to stage j+1. Stage 0 of device 0 takes `ser_in`, and stage 0 of device k+1 takes the old last stage of device k. Without a shift action, or while the clear is active, no stage moves.
- R2: `ser_out` always equals the last stage of the last device. The first bit shifted in after a clear or a reset appears there after `WIDTH*NDEV` shift actions.
- R3: A storage action copies all shift stages into the holding register. Without a storage action, the holding register keeps its value. Bit `WIDTH*k+i` of `par_out` is stage i of device k.
- R4: When a shift action and a storage action fall on the same cycle, the holding register captures the contents from before that shift.
- R5: While the synchronized clear is low, all shift stages and `ser_out` are 0 and the holding register keeps its value. Shift actions during the clear are discarded. Shifting resumes with the first shift action after the clear is released.
- R6: A storage action while the clear is active loads all zeros into the holding register. This holds even in the cycle in which the clear first takes effect.
- R7: When `oe_n` is 1, `par_oe` and `par_out` are all 0. When `oe_n` is 0, `par_oe` is all 1 and `par_out` equals the holding register. This takes effect with no clock delay, and `ser_out` is unaffected.
- R8: A rising strobe or falling clear takes effect on the third rising `clk` edge after the input changes. A strobe held high produces exactly one action.
- R9: While `rst_n` is low, both registers are cleared, so `par_out` and `ser_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| ser_in | input | 1 | Serial data into stage 0 of device 0 |
| shift_stb | input | 1 | Shift strobe; asynchronous, acts on its rising edge |
| store_stb | input | 1 | Storage strobe; asynchronous, acts on its rising edge |
| clear_n | input | 1 | Shift-chain clear, active low, asynchronous |
| oe_n | input | 1 | Parallel output enable, active low |
| par_out | output | WIDTH*NDEV | Parallel output value (0 when disabled) |
| par_oe | output | WIDTH*NDEV | Per-bit drive enable for a pad wrapper |
| ser_out | output | 1 | Cascade output, last stage of last device |

## Verification
A strobe or clear change becomes visible on the third rising clock edge after the bench drives it. The output-enable effect is visible on the same cycle. The bench drives all inputs on falling edges. It samples the outputs on the next falling edge after each rising edge, and in the output-enable tests it samples 1 ns after the change. A behavioural model replays the three-edge pipeline with sample histories, and the outputs are compared with it on every cycle. For the latency requirement, the bench checks that the outputs have not changed after two edges and have changed after the third. The directed checks compare the parallel pattern against the bit order of the shifted word.

// File: rtl/exp_pkg.sv
package exp_pkg;
    localparam int STAGES_DEFAULT = 8;
    localparam int CHAIN_DEFAULT  = 2;

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_t;
endpackage

// File: rtl/exp_sync2.sv
module exp_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/exp_edge_fsm.sv
module exp_edge_fsm
    import exp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    edge_state_t state_q;
    edge_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_LOW:  if (level)  state_d = EDGE_HIGH;
            EDGE_HIGH: if (!level) state_d = EDGE_LOW;
            default:   state_d = EDGE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDGE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse = 1'b0;
        unique case (state_q)
            EDGE_LOW:  pulse = level;
            EDGE_HIGH: pulse = 1'b0;
            default:   pulse = 1'b0;
        endcase
    end

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/exp_shift_core.sv
module exp_shift_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             shift_pulse,
    input  logic             clr,
    output logic [WIDTH-1:0] stages,
    output logic             dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          stages <= '0;
        else if (clr)        stages <= '0;
        else if (shift_pulse) stages <= {stages[WIDTH-2:0], din};
    end

    assign dout = stages[WIDTH-1];

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stages == '0));
    assert_no_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_pulse && !clr) |=> $stable(stages));
endmodule

// File: rtl/exp_hold_out.sv
module exp_hold_out #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clr,
    input  logic [WIDTH-1:0] shift_val,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_out,
    output logic [WIDTH-1:0] par_oe
);
    logic [WIDTH-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= clr ? '0 : shift_val;
    end

    assign par_oe  = {WIDTH{~oe_n}};
    assign par_out = hold_q & par_oe;

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hold_q));
    assert_clear_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && clr) |=> (hold_q == '0));
endmodule

// File: rtl/expander_chain.sv
module expander_chain
    import exp_pkg::*;
#(
    parameter int WIDTH = STAGES_DEFAULT,
    parameter int NDEV  = CHAIN_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_in,
    input  logic                  shift_stb,
    input  logic                  store_stb,
    input  logic                  clear_n,
    input  logic                  oe_n,
    output logic [WIDTH*NDEV-1:0] par_out,
    output logic [WIDTH*NDEV-1:0] par_oe,
    output logic                  ser_out
);
    localparam int NBITS = WIDTH * NDEV;

    logic shift_lvl, store_lvl, clear_lvl_n;
    logic shift_pulse, store_pulse, clr;
    logic [NDEV:0] link;
    logic [NBITS-1:0] stages_all;

    exp_sync2 #(.RST_VAL(1'b0)) u_sync_shift (
        .clk(clk), .rst_n(rst_n), .d(shift_stb), .q(shift_lvl));
    exp_sync2 #(.RST_VAL(1'b0)) u_sync_store (
        .clk(clk), .rst_n(rst_n), .d(store_stb), .q(store_lvl));
    exp_sync2 #(.RST_VAL(1'b1)) u_sync_clear (
        .clk(clk), .rst_n(rst_n), .d(clear_n), .q(clear_lvl_n));

    exp_edge_fsm u_edge_shift (
        .clk(clk), .rst_n(rst_n), .level(shift_lvl), .pulse(shift_pulse));
    exp_edge_fsm u_edge_store (
        .clk(clk), .rst_n(rst_n), .level(store_lvl), .pulse(store_pulse));

    assign clr     = ~clear_lvl_n;
    assign link[0] = ser_in;

    for (genvar k = 0; k < NDEV; k++) begin : g_dev
        exp_shift_core #(.WIDTH(WIDTH)) u_shift (
            .clk        (clk),
            .rst_n      (rst_n),
            .din        (link[k]),
            .shift_pulse(shift_pulse),
            .clr        (clr),
            .stages     (stages_all[WIDTH*k +: WIDTH]),
            .dout       (link[k+1])
        );
        exp_hold_out #(.WIDTH(WIDTH)) u_hold (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (store_pulse),
            .clr      (clr),
            .shift_val(stages_all[WIDTH*k +: WIDTH]),
            .oe_n     (oe_n),
            .par_out  (par_out[WIDTH*k +: WIDTH]),
            .par_oe   (par_oe[WIDTH*k +: WIDTH])
        );
    end

    assign ser_out = link[NDEV];

    if (NDEV > 1) begin : g_link_chk
        assert_chain_link_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (shift_pulse && !clr) |=> (stages_all[WIDTH] == $past(stages_all[WIDTH-1])));
    end

    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (par_oe == '0 && par_out == '0));
    assert_serial_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !ser_out);
endmodule

// File: tb/tb_expander_chain.sv
module tb_expander_chain;
    localparam int WIDTH = 8;
    localparam int NDEV  = 2;
    localparam int NB    = WIDTH * NDEV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0, shift_stb = 1'b0, store_stb = 1'b0;
    logic clear_n = 1'b1, oe_n = 1'b0;
    logic [NB-1:0] par_out, par_oe;
    logic ser_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    expander_chain #(.WIDTH(WIDTH), .NDEV(NDEV)) dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_stb(shift_stb),
        .store_stb(store_stb), .clear_n(clear_n), .oe_n(oe_n),
        .par_out(par_out), .par_oe(par_oe), .ser_out(ser_out));

    always #2 clk = ~clk;

    // Behavioural reference: inputs act three edges after they are sampled.
    logic [NB-1:0] m_shift, m_hold;
    logic [2:0] h_sh, h_st, h_cl;
    logic m_sp, m_tp, m_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_shift = '0; m_hold = '0;
            h_sh = '0; h_st = '0; h_cl = 3'b111;
        end else begin
            m_sp  = h_sh[1] && !h_sh[2];
            m_tp  = h_st[1] && !h_st[2];
            m_clr = !h_cl[1];
            if (m_tp) m_hold = m_clr ? '0 : m_shift;
            if (m_clr)     m_shift = '0;
            else if (m_sp) m_shift = {m_shift[NB-2:0], ser_in};
            h_sh = {h_sh[1:0], shift_stb};
            h_st = {h_st[1:0], store_stb};
            h_cl = {h_cl[1:0], clear_n};
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (par_out !== (oe_n ? '0 : m_hold) || par_oe !== {NB{~oe_n}}
                || ser_out !== m_shift[NB-1]) begin
                failures++;
                $display("FAIL R8 model: par_out=%h par_oe=%h ser_out=%b exp %h %h %b",
                         par_out, par_oe, ser_out, oe_n ? '0 : m_hold,
                         {NB{~oe_n}}, m_shift[NB-1]);
            end
        end
    end

    task automatic chk(string req, logic [NB-1:0] act, logic [NB-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(logic b);
        ser_in = b; shift_stb = 1'b1; tick(4); shift_stb = 1'b0; tick(4);
    endtask

    task automatic store();
        store_stb = 1'b1; tick(4); store_stb = 1'b0; tick(4);
    endtask

    task automatic shift_and_store(logic b);
        ser_in = b; shift_stb = 1'b1; store_stb = 1'b1; tick(4);
        shift_stb = 1'b0; store_stb = 1'b0; tick(4);
    endtask

    function automatic logic [NB-1:0] rev(logic [NB-1:0] v);
        logic [NB-1:0] r;
        for (int i = 0; i < NB; i++) r[i] = v[NB-1-i];
        return r;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NB-1:0] pat;
        logic [NB-1:0] sreg;
        logic [NB-1:0] hsave;
        pat = 16'hA53D;
        tick(3);
        // R9: reset state
        chk("R9 par_out", par_out, '0);
        chk("R9 ser_out", {15'd0, ser_out}, '0);
        @(negedge clk); rst_n = 1'b1; tick(2);

        // R1, R2: shift the word in
        for (int i = 0; i < NB; i++) begin
            shift_bit(pat[i]);
            if (i == NB - 2) chk("R2 before far end", {15'd0, ser_out}, '0);
        end
        sreg = rev(pat);
        chk("R2 first bit at far end", {15'd0, ser_out}, {15'd0, pat[0]});
        chk("R3 outputs before store", par_out, '0);
        store();
        chk("R1 R3 stored word", par_out, sreg);

        // R7: output enable
        oe_n = 1'b1; #1;
        chk("R7 disabled value", par_out, '0);
        chk("R7 disabled enable", par_oe, '0);
        chk("R7 ser_out unaffected", {15'd0, ser_out}, {15'd0, sreg[NB-1]});
        @(negedge clk); oe_n = 1'b0; #1;
        chk("R7 enabled value", par_out, sreg);
        chk("R7 enabled enable", par_oe, '1);
        tick(1);

        // R4: simultaneous strobes
        shift_and_store(1'b0);
        chk("R4 pre-shift captured", par_out, sreg);
        sreg = {sreg[NB-2:0], 1'b0};
        store();
        chk("R4 shifted word", par_out, sreg);

        // R8: latency and held strobe
        hsave = par_out;
        shift_bit(1'b1);
        sreg = {sreg[NB-2:0], 1'b1};
        store_stb = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R8 unchanged after two edges", par_out, hsave);
        @(posedge clk); @(negedge clk);
        chk("R8 changed after third edge", par_out, sreg);
        tick(2); store_stb = 1'b0; tick(3);
        ser_in = 1'b0; shift_stb = 1'b1; tick(20); shift_stb = 1'b0; tick(4);
        store();
        chk("R8 one action per held strobe", par_out, {sreg[NB-2:0], 1'b0});
        sreg = {sreg[NB-2:0], 1'b0};

        // R5: clear keeps holding register, zeros chain
        clear_n = 1'b0; tick(4);
        chk("R5 ser_out cleared", {15'd0, ser_out}, '0);
        chk("R5 holding kept", par_out, sreg);
        shift_bit(1'b1);
        shift_bit(1'b1);
        clear_n = 1'b1; tick(4);
        shift_bit(1'b1);
        store();
        chk("R5 shifts during clear discarded", par_out, {{(NB-1){1'b0}}, 1'b1});

        // R6: store in the cycle the clear takes effect
        for (int i = 0; i < 4; i++) shift_bit(1'b1);
        store();
        chk("R6 setup", par_out, 16'h001F);
        clear_n = 1'b0; store_stb = 1'b1; tick(4);
        chk("R6 store during clear", par_out, '0);
        store_stb = 1'b0; clear_n = 1'b1; tick(6);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule